// File: doc/BRIEF.md
# Serial Host Control Register Interface

This block is a four-wire serial slave that a host processor uses to program a four-channel voice codec. The host frames each 8-bit transfer with an active-low select. A transfer that begins with a 1 writes a configuration byte. A transfer that begins with a 0 writes the register that the stored configuration points at. That register is a time-slot register, a signaling-control register or one half of a 14-bit gain coefficient. The block presents the programmed values as decoded outputs: companding law, frame timing mode, per-channel receive/transmit enables, slot numbers, gain coefficients, signaling outputs and signaling pin directions.

When signaling mode is configured, the status byte of the addressed channel shifts out on the serial data output while the control byte is shifted in. A command-driven alternative read method lets the host tie data in and data out to one wire. In that method the output is driven only during a dedicated read transfer, and the input is ignored during that transfer.

The serial pins are sampled in the block's own clock domain. That clock must run at least eight times faster than the serial clock. The serial clock idles high. Every register write takes effect when the select rises after a complete byte.

Top module: `shc_top`

## Requirements
- R1: A transfer is the bits sampled on falling serial-clock edges while select is low, most significant bit first. Exactly eight bits form a byte, and clocks after the eighth are ignored. The resulting write takes effect only after select rises.
- R2: A byte with bit 7 = 1 that is not one of the commands 0xFD, 0xFE or 0xFF stores bits 6:0 as the configuration. A byte with bit 7 = 0 writes the register selected by the stored configuration, whose bits 3:2 give the channel.
- R3: After reset, A-law (`alaw_sel`=1) and delay timing (`delay_sel`=1) are selected and all enables are 0. All slots, gains, signaling outputs and directions are 0, and `sc_dout_oe` is 0. The stored configuration addresses channel 0 with codec mode A-law.
- R4: A configuration byte with mode bits 6:5 = 00 sets `alaw_sel`=0, and one with 6:5 = 01 sets `alaw_sel`=1. Both also set `delay_sel` to bit 4. Configurations with mode 10 or 11 leave both outputs unchanged.
- R5: In codec mode, a data byte sets the selected channel's receive enable to configuration bit 0 and its transmit enable to bit 1. It also loads data bits 6:0 into the receive slot when bit 0 is 1 and into the transmit slot when bit 1 is 1. Code 00 clears both enables and keeps both slots.
- R6: In gain mode (bits 6:4 = 100), a data byte writes data bits 6:0 into one half of a 14-bit coefficient. Configuration bit 1 selects the path (1 = transmit, 0 = receive), and bit 0 selects the half (1 = bits 13:7, 0 = bits 6:0). The other half and the other path are unchanged.
- R7: In signaling mode (bits 6:4 = 101), a data byte stores data bits 4:0 as the channel's signaling outputs and configuration bits 1:0 as its pin directions. During the same transfer, the channel's 8-bit status shifts out MSB first. The first bit is valid from select low, and each later bit follows a rising serial-clock edge.
- R8: `sc_dout_oe` is 0 while select is high and during every transfer that is not a read.
- R9: A transfer with fewer than eight bits changes no register and no output.
- R10: With stored mode 11, a data byte changes no register.
- R11: Commands never change the configuration. 0xFE arms the alternative read method and 0xFD disarms it. While the method is armed, signaling transfers still write but leave the output undriven.
- R12: While armed with signaling mode configured, 0xFF makes the next transfer a read. During that transfer the selected status is driven out and the input byte is discarded. 0xFF in any other state has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock, at least 8x the serial clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sc_cs_n | input | 1 | Serial select, active low |
| sc_clk | input | 1 | Serial clock, idles high |
| sc_din | input | 1 | Serial data in |
| sc_dout | output | 1 | Serial data out |
| sc_dout_oe | output | 1 | Output enable for the serial data out driver |
| line_status | input | NUM_CH*8 | Status byte of each channel, channel n at bits 8n+7:8n |
| alaw_sel | output | 1 | 1 = A-law, 0 = mu-law |
| delay_sel | output | 1 | 1 = delay timing, 0 = non-delay |
| tx_enable | output | NUM_CH | Transmit enable per channel |
| rx_enable | output | NUM_CH | Receive enable per channel |
| tx_slot | output | NUM_CH*7 | Transmit slot number per channel |
| rx_slot | output | NUM_CH*7 | Receive slot number per channel |
| tx_gain | output | NUM_CH*14 | Transmit gain coefficient per channel |
| rx_gain | output | NUM_CH*14 | Receive gain coefficient per channel |
| sig_ctrl | output | NUM_CH*5 | Signaling output values per channel |
| sig_dir | output | NUM_CH*2 | Signaling pin direction bits per channel |

## Verification
The hardest state to reach from the ports is the pending read of the alternative method. The bench reaches it with a sequence of its own: a signaling configuration, the arm command, a plain signaling write, the read command, and a following transfer. That last transfer must drive status out while its input byte changes nothing. It is followed by a disarm and a data byte that shows the configuration survived all the commands. Truncated transfers are produced by raising select after five clocks, both on a configuration byte and on a data byte. Gain halves are written with distinct values so that a swapped half or path shows up in the coefficient.

// File: rtl/shc_pkg.sv
package shc_pkg;

    localparam int BYTE_W = 8;
    localparam int CFG_W  = 7;

    typedef enum logic [1:0] {
        MODE_ULAW    = 2'b00,
        MODE_ALAW    = 2'b01,
        MODE_SIGGAIN = 2'b10,
        MODE_RSVD    = 2'b11
    } mode_e;

    localparam logic [BYTE_W-1:0] CMD_DISARM = 8'hFD;
    localparam logic [BYTE_W-1:0] CMD_ARM    = 8'hFE;
    localparam logic [BYTE_W-1:0] CMD_READ   = 8'hFF;

    // mode A-law, delay timing, channel 0, code 00
    localparam logic [CFG_W-1:0] CFG_RESET = 7'b011_0000;

endpackage

// File: rtl/shc_sync.sv
module shc_sync #(
    parameter int                WIDTH   = 3,
    parameter int                STAGES  = 2,
    parameter logic [WIDTH-1:0]  RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);

    logic [WIDTH-1:0] pipe_d [STAGES];
    logic [WIDTH-1:0] pipe_q [STAGES];

    always_comb begin
        pipe_d[0] = async_i;
        for (int s = 1; s < STAGES; s++) begin
            pipe_d[s] = pipe_q[s-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int s = 0; s < STAGES; s++) pipe_q[s] <= RST_VAL;
        end else begin
            for (int s = 0; s < STAGES; s++) pipe_q[s] <= pipe_d[s];
        end
    end

    assign sync_o = pipe_q[STAGES-1];

endmodule

// File: rtl/shc_frame.sv
module shc_frame
    import shc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n_s,
    input  logic              sck_s,
    input  logic              din_s,
    input  logic [BYTE_W-1:0] load_byte,
    output logic              active_o,
    output logic              tx_bit_o,
    output logic [BYTE_W-1:0] rx_byte_o,
    output logic              done_o,
    output logic              end_o
);

    localparam int              CNT_W = $clog2(BYTE_W + 1);
    localparam logic [CNT_W-1:0] FULL = CNT_W'(BYTE_W);

    typedef struct packed {
        logic              cs_prev;
        logic              sck_prev;
        logic              active;
        logic [CNT_W-1:0]  cnt;
        logic [BYTE_W-1:0] rx;
        logic [BYTE_W-1:0] tx;
        logic              done;
        logic              fin;
    } frame_t;

    frame_t q, d;
    logic   cs_fall, cs_rise, sck_fall, sck_rise;

    assign cs_fall  = !cs_n_s &&  q.cs_prev;
    assign cs_rise  =  cs_n_s && !q.cs_prev;
    assign sck_fall = !sck_s  &&  q.sck_prev;
    assign sck_rise =  sck_s  && !q.sck_prev;

    always_comb begin
        d          = q;
        d.cs_prev  = cs_n_s;
        d.sck_prev = sck_s;
        d.done     = 1'b0;
        d.fin      = 1'b0;
        if (cs_fall) begin
            d.active = 1'b1;
            d.cnt    = '0;
            d.tx     = load_byte;
        end else if (q.active) begin
            if (cs_rise) begin
                d.active = 1'b0;
                d.fin    = 1'b1;
                d.done   = (q.cnt == FULL);
            end else begin
                if (sck_fall && (q.cnt < FULL)) begin
                    d.rx  = {q.rx[BYTE_W-2:0], din_s};
                    d.cnt = q.cnt + 1'b1;
                end
                if (sck_rise && (q.cnt != '0)) begin
                    d.tx = {q.tx[BYTE_W-2:0], 1'b0};
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q          <= '0;
            q.cs_prev  <= 1'b1;
            q.sck_prev <= 1'b1;
        end else begin
            q <= d;
        end
    end

    assign active_o  = q.active;
    assign tx_bit_o  = q.tx[BYTE_W-1];
    assign rx_byte_o = q.rx;
    assign done_o    = q.done;
    assign end_o     = q.fin;

    // R1: no byte is reported unless a frame was open when select rose
    p_done_needs_frame_r1: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> $past(active_o));

    // R7: the output bit only moves on a rising serial clock or a new frame
    p_tx_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (active_o && !sck_rise && !cs_fall) |=> $stable(tx_bit_o));

endmodule

// File: rtl/shc_regs.sv
module shc_regs
    import shc_pkg::*;
#(
    parameter int NUM_CH = 4,
    parameter int SLOT_W = 7,
    parameter int HALF_W = 7
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           frame_end,
    input  logic                           frame_ok,
    input  logic [BYTE_W-1:0]              rx_byte,
    input  logic [NUM_CH*BYTE_W-1:0]       line_status,
    output logic [BYTE_W-1:0]              status_byte,
    output logic                           drive_o,
    output logic                           alaw_o,
    output logic                           delay_o,
    output logic [NUM_CH-1:0]              tx_en_o,
    output logic [NUM_CH-1:0]              rx_en_o,
    output logic [NUM_CH*SLOT_W-1:0]       tx_slot_o,
    output logic [NUM_CH*SLOT_W-1:0]       rx_slot_o,
    output logic [NUM_CH*2*HALF_W-1:0]     tx_gain_o,
    output logic [NUM_CH*2*HALF_W-1:0]     rx_gain_o,
    output logic [NUM_CH*5-1:0]            sig_ctrl_o,
    output logic [NUM_CH*2-1:0]            sig_dir_o
);

    localparam int CH_W   = $clog2(NUM_CH);
    localparam int GAIN_W = 2 * HALF_W;
    localparam int SIG_W  = 5;

    typedef struct packed {
        logic [CFG_W-1:0]                    cfg;
        logic                                alaw;
        logic                                delay;
        logic                                armed;
        logic                                pend;
        logic [NUM_CH-1:0]                   tx_en;
        logic [NUM_CH-1:0]                   rx_en;
        logic [NUM_CH-1:0][SLOT_W-1:0]       tx_slot;
        logic [NUM_CH-1:0][SLOT_W-1:0]       rx_slot;
        logic [NUM_CH-1:0][GAIN_W-1:0]       tx_gain;
        logic [NUM_CH-1:0][GAIN_W-1:0]       rx_gain;
        logic [NUM_CH-1:0][SIG_W-1:0]        sig;
        logic [NUM_CH-1:0][1:0]              dir;
    } regs_t;

    regs_t                          q, d;
    logic [NUM_CH-1:0][BYTE_W-1:0]  stat_v;
    logic [CH_W-1:0]                ch;
    mode_e                          mode;
    logic                           sig_mode;

    assign stat_v      = line_status;
    assign ch          = q.cfg[2 +: CH_W];
    assign mode        = mode_e'(q.cfg[6:5]);
    assign sig_mode    = (mode == MODE_SIGGAIN) && q.cfg[4];
    assign status_byte = stat_v[ch];
    assign drive_o     = q.pend || (sig_mode && !q.armed);

    always_comb begin
        d = q;
        if (frame_end) d.pend = 1'b0;
        if (frame_ok && !q.pend) begin
            if (rx_byte[BYTE_W-1]) begin
                if (rx_byte == CMD_ARM) begin
                    d.armed = 1'b1;
                end else if (rx_byte == CMD_DISARM) begin
                    d.armed = 1'b0;
                end else if (rx_byte == CMD_READ) begin
                    d.pend = q.armed && sig_mode;
                end else begin
                    d.cfg = rx_byte[CFG_W-1:0];
                    if (!rx_byte[6]) begin
                        d.alaw  = rx_byte[5];
                        d.delay = rx_byte[4];
                    end
                end
            end else begin
                case (mode)
                    MODE_ULAW, MODE_ALAW: begin
                        d.rx_en[ch] = q.cfg[0];
                        d.tx_en[ch] = q.cfg[1];
                        if (q.cfg[0]) d.rx_slot[ch] = rx_byte[SLOT_W-1:0];
                        if (q.cfg[1]) d.tx_slot[ch] = rx_byte[SLOT_W-1:0];
                    end
                    MODE_SIGGAIN: begin
                        if (q.cfg[4]) begin
                            d.sig[ch] = rx_byte[SIG_W-1:0];
                            d.dir[ch] = q.cfg[1:0];
                        end else if (q.cfg[1]) begin
                            d.tx_gain[ch][(q.cfg[0] ? HALF_W : 0) +: HALF_W] = rx_byte[HALF_W-1:0];
                        end else begin
                            d.rx_gain[ch][(q.cfg[0] ? HALF_W : 0) +: HALF_W] = rx_byte[HALF_W-1:0];
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q       <= '0;
            q.cfg   <= CFG_RESET;
            q.alaw  <= 1'b1;
            q.delay <= 1'b1;
        end else begin
            q <= d;
        end
    end

    assign alaw_o     = q.alaw;
    assign delay_o    = q.delay;
    assign tx_en_o    = q.tx_en;
    assign rx_en_o    = q.rx_en;
    assign tx_slot_o  = q.tx_slot;
    assign rx_slot_o  = q.rx_slot;
    assign tx_gain_o  = q.tx_gain;
    assign rx_gain_o  = q.rx_gain;
    assign sig_ctrl_o = q.sig;
    assign sig_dir_o  = q.dir;

    // R10: data written under the reserved mode leaves every register alone
    p_rsvd_noeffect_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_ok && !rx_byte[BYTE_W-1] && mode == MODE_RSVD) |=>
        ($stable(tx_slot_o) && $stable(rx_slot_o) && $stable(tx_gain_o) &&
         $stable(rx_gain_o) && $stable(sig_ctrl_o) && $stable(tx_en_o) && $stable(rx_en_o)));

    // R11: a command byte never moves the decoded law or timing
    p_cmd_keeps_cfg_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_ok && (rx_byte == CMD_ARM || rx_byte == CMD_DISARM || rx_byte == CMD_READ)) |=>
        ($stable(alaw_o) && $stable(delay_o)));

    // R9: a truncated frame changes nothing
    p_discard_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_end && !frame_ok) |=>
        ($stable(tx_slot_o) && $stable(tx_gain_o) && $stable(rx_gain_o) &&
         $stable(sig_ctrl_o) && $stable(alaw_o) && $stable(tx_en_o)));

    // R6: a gain write leaves the other path's coefficient untouched
    p_gain_path_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_ok && !q.pend && !rx_byte[BYTE_W-1] && q.cfg[6:4] == 3'b100) |=>
        ($past(q.cfg[1]) ? $stable(rx_gain_o) : $stable(tx_gain_o)));

endmodule

// File: rtl/shc_top.sv
module shc_top
    import shc_pkg::*;
#(
    parameter int NUM_CH      = 4,
    parameter int SLOT_W      = 7,
    parameter int HALF_W      = 7,
    parameter int SYNC_STAGES = 2
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        sc_cs_n,
    input  logic                        sc_clk,
    input  logic                        sc_din,
    output logic                        sc_dout,
    output logic                        sc_dout_oe,
    input  logic [NUM_CH*BYTE_W-1:0]    line_status,
    output logic                        alaw_sel,
    output logic                        delay_sel,
    output logic [NUM_CH-1:0]           tx_enable,
    output logic [NUM_CH-1:0]           rx_enable,
    output logic [NUM_CH*SLOT_W-1:0]    tx_slot,
    output logic [NUM_CH*SLOT_W-1:0]    rx_slot,
    output logic [NUM_CH*2*HALF_W-1:0]  tx_gain,
    output logic [NUM_CH*2*HALF_W-1:0]  rx_gain,
    output logic [NUM_CH*5-1:0]         sig_ctrl,
    output logic [NUM_CH*2-1:0]         sig_dir
);

    logic [2:0]        pins_s;
    logic              active, tx_bit, done, fin, drive;
    logic [BYTE_W-1:0] rx_byte, status_byte;

    shc_sync #(
        .WIDTH   (3),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (3'b011)
    ) i_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i ({sc_din, sc_clk, sc_cs_n}),
        .sync_o  (pins_s)
    );

    shc_frame i_frame (
        .clk       (clk),
        .rst_n     (rst_n),
        .cs_n_s    (pins_s[0]),
        .sck_s     (pins_s[1]),
        .din_s     (pins_s[2]),
        .load_byte (status_byte),
        .active_o  (active),
        .tx_bit_o  (tx_bit),
        .rx_byte_o (rx_byte),
        .done_o    (done),
        .end_o     (fin)
    );

    shc_regs #(
        .NUM_CH (NUM_CH),
        .SLOT_W (SLOT_W),
        .HALF_W (HALF_W)
    ) i_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .frame_end   (fin),
        .frame_ok    (done),
        .rx_byte     (rx_byte),
        .line_status (line_status),
        .status_byte (status_byte),
        .drive_o     (drive),
        .alaw_o      (alaw_sel),
        .delay_o     (delay_sel),
        .tx_en_o     (tx_enable),
        .rx_en_o     (rx_enable),
        .tx_slot_o   (tx_slot),
        .rx_slot_o   (rx_slot),
        .tx_gain_o   (tx_gain),
        .rx_gain_o   (rx_gain),
        .sig_ctrl_o  (sig_ctrl),
        .sig_dir_o   (sig_dir)
    );

    assign sc_dout_oe = active && drive;
    assign sc_dout    = active && tx_bit;

    // R8: once the synchronised select is high the driver is released
    p_hiz_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        pins_s[0] |=> !sc_dout_oe);

endmodule

// File: tb/test_shc_top.sv
module test_shc_top;

    localparam int NCH  = 4;
    localparam int HALF = 8;
    localparam int GAP  = 48;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sc_cs_n = 1'b1, sc_clk = 1'b1, sc_din = 1'b0;
    logic sc_dout, sc_dout_oe;
    logic [NCH*8-1:0]  line_status;
    logic              alaw_sel, delay_sel;
    logic [NCH-1:0]    tx_enable, rx_enable;
    logic [NCH*7-1:0]  tx_slot, rx_slot;
    logic [NCH*14-1:0] tx_gain, rx_gain;
    logic [NCH*5-1:0]  sig_ctrl;
    logic [NCH*2-1:0]  sig_dir;

    always #5 clk = ~clk;

    shc_top i_shc_top (
        .clk(clk), .rst_n(rst_n), .sc_cs_n(sc_cs_n), .sc_clk(sc_clk), .sc_din(sc_din),
        .sc_dout(sc_dout), .sc_dout_oe(sc_dout_oe), .line_status(line_status),
        .alaw_sel(alaw_sel), .delay_sel(delay_sel), .tx_enable(tx_enable), .rx_enable(rx_enable),
        .tx_slot(tx_slot), .rx_slot(rx_slot), .tx_gain(tx_gain), .rx_gain(rx_gain),
        .sig_ctrl(sig_ctrl), .sig_dir(sig_dir)
    );

    int    n_checks = 0;
    int    n_err    = 0;
    bit    settled  = 0;
    bit    finished = 0;
    string cur_req  = "R3";

    // behavioural model state
    logic [6:0]  m_cfg;
    logic        m_alaw, m_delay, m_armed, m_pend;
    logic        m_txen [NCH];
    logic        m_rxen [NCH];
    logic [6:0]  m_txslot [NCH];
    logic [6:0]  m_rxslot [NCH];
    logic [13:0] m_txgain [NCH];
    logic [13:0] m_rxgain [NCH];
    logic [4:0]  m_sig [NCH];
    logic [1:0]  m_dir [NCH];

    function automatic logic [7:0] stat_of(int c);
        return 8'h3C ^ 8'(c * 8'h51);
    endfunction

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic bit model_sig();
        return m_cfg[6:4] == 3'b101;
    endfunction

    task automatic model_reset();
        m_cfg = 7'b011_0000; m_alaw = 1; m_delay = 1; m_armed = 0; m_pend = 0;
        for (int c = 0; c < NCH; c++) begin
            m_txen[c] = 0; m_rxen[c] = 0; m_txslot[c] = 0; m_rxslot[c] = 0;
            m_txgain[c] = 0; m_rxgain[c] = 0; m_sig[c] = 0; m_dir[c] = 0;
        end
    endtask

    task automatic model_apply(input logic [7:0] b, input int nbits);
        int c;
        c = int'(m_cfg[3:2]);
        if (nbits != 8 || m_pend) begin
            m_pend = 0;
            return;
        end
        if (b == 8'hFE) m_armed = 1;
        else if (b == 8'hFD) m_armed = 0;
        else if (b == 8'hFF) m_pend = m_armed && model_sig();
        else if (b[7]) begin
            m_cfg = b[6:0];
            if (!b[6]) begin m_alaw = b[5]; m_delay = b[4]; end
        end else if (!m_cfg[6]) begin
            m_rxen[c] = m_cfg[0];
            m_txen[c] = m_cfg[1];
            if (m_cfg[0]) m_rxslot[c] = b[6:0];
            if (m_cfg[1]) m_txslot[c] = b[6:0];
        end else if (m_cfg[6:4] == 3'b101) begin
            m_sig[c] = b[4:0];
            m_dir[c] = m_cfg[1:0];
        end else if (m_cfg[6:4] == 3'b100) begin
            if (m_cfg[1]) begin
                if (m_cfg[0]) m_txgain[c][13:7] = b[6:0]; else m_txgain[c][6:0] = b[6:0];
            end else begin
                if (m_cfg[0]) m_rxgain[c][13:7] = b[6:0]; else m_rxgain[c][6:0] = b[6:0];
            end
        end
    endtask

    task automatic compare_all();
        chk(cur_req, "alaw_sel (R4)", 32'(alaw_sel), 32'(m_alaw));
        chk(cur_req, "delay_sel (R4)", 32'(delay_sel), 32'(m_delay));
        chk(cur_req, "dout_oe idle (R8)", 32'(sc_dout_oe), 32'd0);
        for (int c = 0; c < NCH; c++) begin
            chk(cur_req, $sformatf("tx_en[%0d] (R5)", c), 32'(tx_enable[c]), 32'(m_txen[c]));
            chk(cur_req, $sformatf("rx_en[%0d] (R5)", c), 32'(rx_enable[c]), 32'(m_rxen[c]));
            chk(cur_req, $sformatf("tx_slot[%0d] (R5)", c), 32'(tx_slot[c*7 +: 7]), 32'(m_txslot[c]));
            chk(cur_req, $sformatf("rx_slot[%0d] (R5)", c), 32'(rx_slot[c*7 +: 7]), 32'(m_rxslot[c]));
            chk(cur_req, $sformatf("tx_gain[%0d] (R6)", c), 32'(tx_gain[c*14 +: 14]), 32'(m_txgain[c]));
            chk(cur_req, $sformatf("rx_gain[%0d] (R6)", c), 32'(rx_gain[c*14 +: 14]), 32'(m_rxgain[c]));
            chk(cur_req, $sformatf("sig_ctrl[%0d] (R7)", c), 32'(sig_ctrl[c*5 +: 5]), 32'(m_sig[c]));
            chk(cur_req, $sformatf("sig_dir[%0d] (R7)", c), 32'(sig_dir[c*2 +: 2]), 32'(m_dir[c]));
        end
    endtask

    // compare against the model on every clock while no transfer is in flight
    always @(negedge clk) begin
        if (settled && !finished) compare_all();
    end

    task automatic xfer(input logic [7:0] b, input int nbits);
        logic       exp_oe;
        logic [7:0] exp_stat;
        @(negedge clk);
        settled  = 0;
        exp_oe   = m_pend || (model_sig() && !m_armed);
        exp_stat = stat_of(int'(m_cfg[3:2]));
        sc_cs_n  = 1'b0;
        for (int i = 0; i < nbits; i++) begin
            sc_din = b[7-i];
            repeat (HALF) @(negedge clk);
            chk(cur_req, $sformatf("dout_oe bit%0d (R8)", i), 32'(sc_dout_oe), 32'(exp_oe));
            if (exp_oe)
                chk(cur_req, $sformatf("status bit%0d (R7)", i), 32'(sc_dout), 32'(exp_stat[7-i]));
            sc_clk = 1'b0;
            repeat (HALF) @(negedge clk);
            sc_clk = 1'b1;
        end
        repeat (HALF) @(negedge clk);
        sc_cs_n = 1'b1;
        model_apply(b, nbits);
        repeat (GAP) @(negedge clk);
        settled = 1;
    endtask

    initial begin
        for (int c = 0; c < NCH; c++) line_status[c*8 +: 8] = stat_of(c);
        model_reset();
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        cur_req = "R3";
        settled = 1;
        repeat (10) @(negedge clk);

        cur_req = "R4";
        xfer(8'b1000_0000, 8);          // mu-law, non-delay
        xfer(8'b1011_0000, 8);          // A-law, delay

        cur_req = "R5";
        xfer(8'b1001_0111, 8); xfer(8'h2A, 8);   // ch1 both
        xfer(8'b1001_1001, 8); xfer(8'h05, 8);   // ch2 receive only
        xfer(8'b1001_1010, 8); xfer(8'h7F, 8);   // ch2 transmit only
        xfer(8'b1001_0100, 8); xfer(8'h00, 8);   // ch1 power down, slots kept

        cur_req = "R2";
        xfer(8'b1000_1111, 8); xfer(8'h41, 8);   // ch3 both, mu-law

        cur_req = "R6";
        xfer(8'b1100_1111, 8); xfer(8'h14, 8);   // ch3 tx upper
        xfer(8'b1100_1110, 8); xfer(8'h0B, 8);   // ch3 tx lower -> 2571
        xfer(8'b1100_0001, 8); xfer(8'h0D, 8);   // ch0 rx upper
        xfer(8'b1100_0000, 8); xfer(8'h0B, 8);   // ch0 rx lower -> 1675

        cur_req = "R7";
        xfer(8'b1101_1001, 8); xfer(8'h15, 8);   // ch2 signaling, dir 01
        xfer(8'b1101_0010, 8); xfer(8'h0A, 8);   // ch0 signaling, dir 10

        cur_req = "R9";
        xfer(8'b1000_0000, 5);                   // truncated config
        xfer(8'h1F, 5);                          // truncated data

        cur_req = "R10";
        xfer(8'b1110_0100, 8); xfer(8'h33, 8);   // reserved mode, ch1

        cur_req = "R12";
        xfer(8'hFF, 8);                          // not armed: no effect
        xfer(8'hFE, 8);                          // arm while reserved mode
        xfer(8'hFF, 8);                          // armed but not signaling: no effect
        xfer(8'h12, 8);

        cur_req = "R11";
        xfer(8'b1101_0111, 8);                   // ch1 signaling, dir 11
        xfer(8'h1F, 8);                          // armed: write, no drive
        cur_req = "R12";
        xfer(8'hFF, 8);                          // request read
        xfer(8'h00, 8);                          // read cycle, input discarded
        cur_req = "R11";
        xfer(8'hFD, 8);                          // disarm
        xfer(8'h03, 8);                          // config survived commands

        cur_req = "R1";
        xfer(8'b1010_0000, 8); xfer(8'b1001_1011, 8); xfer(8'h60, 8);

        repeat (20) @(negedge clk);
        if (!finished) begin
            finished = 1;
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_checks++;
            n_err++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
            $finish;
        end
    end

endmodule